// File: doc/BRIEF.md
# Sample-Pulse-Gated Configuration Buffer

This block sits between a producer of channel-configuration words and a multiplexed acquisition front end. It has several parallel lanes. Each lane holds a small queue and a registered output word. A single write request carries one word per lane and a lane-select mask. The request either commits to every selected lane in the same cycle or to none of them. A lane that is full blocks the request. A count of clock ticks bounds how long the request may stay blocked.

The first word that reaches a lane goes straight to that lane's output and marks the lane as primed. After that, the output of a primed lane changes only when a sample pulse arrives. Each pulse takes the oldest queued word. If the queue is empty, the pulse presents the current word again. A pulse that arrives before a lane is primed has no effect on that lane.

The write side is a two-state machine. In `ST_IDLE`, `in_ready` is high and a request is taken. The request takes one of four paths:
- It commits at once: IDLE→IDLE.
- It is rejected at once: IDLE→IDLE.
- It is parked in `ST_WAIT`: IDLE→WAIT.
- It leaves `ST_WAIT` on commit or on expiry: WAIT→IDLE. Otherwise it stays blocked: WAIT→WAIT.

Top module: `cfg_pulse_buffer`

## Requirements
- R1: On reset, every lane output word is zero, every `lane_primed` bit is 0, every `cfg_strobe` bit is 0, `wr_done` and `wr_timed_out` are 0, and `in_ready` is 1.
- R2: The first word committed to an unprimed lane appears on that lane's slice of `cfg_out` one clock after the commit, with no sample pulse. In the same cycle `cfg_strobe` for the lane is 1 and `lane_primed` for the lane goes to 1. `lane_primed` then stays 1 until reset.
- R3: A `sample_pulse` on an unprimed lane is ignored: no strobe, and the output word is unchanged.
- R4: On a primed lane, a committed word is queued and the output does not change. Each `sample_pulse` moves the oldest queued word to the output, one clock later, with `cfg_strobe` for the lane set to 1. Words leave in the order they were written.
- R5: If a primed lane's queue is empty at a `sample_pulse`, the lane presents its current word again and raises `cfg_strobe` for one cycle.
- R6: A request that selects a full lane never overwrites queued data. It waits in `ST_WAIT`, and it commits (`wr_done`) once every selected lane has room. With a positive timeout T, if the request is still blocked after T ticks in `ST_WAIT`, `wr_timed_out` pulses. `wr_done` and `wr_timed_out` are never 1 together.
- R7: A timeout of 0 that meets a full selected lane pulses `wr_timed_out` one clock after the request, and the request is dropped.
- R8: A negative timeout (all ones is -1) never expires. The request waits until room appears.
- R9: A timed-out request writes no lane, not even a selected lane that had room. All queues and outputs are left unchanged.
- R10: The lane mask is bit i for lane i. The word for lane i is `in_data[i*WIDTH +: WIDTH]`. A request commits only if every selected lane has room, and then it writes all of them in the same cycle.
- R11: `in_ready` is 0 while a request waits in `ST_WAIT`. A request presented in the clock cycle that follows a cycle with `in_ready` low is discarded, even with `in_valid` high: no `wr_done`, no `wr_timed_out`, and no lane is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Write request present |
| in_mask | input | LANES | Lane-select mask for the request |
| in_data | input | LANES*WIDTH | One configuration word per lane |
| in_timeout | input | TOW | Signed timeout in clock ticks; 0 means immediate, negative means forever |
| in_ready | output | 1 | Write side able to take a request |
| wr_done | output | 1 | One-cycle pulse: the request was committed |
| wr_timed_out | output | 1 | One-cycle pulse: the request expired and nothing was written |
| sample_pulse | input | 1 | Sample pulse from the acquisition timing |
| lane_primed | output | LANES | Per-lane primed flag |
| cfg_out | output | LANES*WIDTH | Per-lane configuration word presented to the front end |
| cfg_strobe | output | LANES | Per-lane pulse: the output word was (re)transferred |

## Verification
The bench builds the block with two lanes, 16-bit words, a queue depth of 4 and an 8-bit timeout. With a depth of 4, a lane fills after a handful of writes, so the blocked, expiring and forever-waiting paths are all reached quickly. With two lanes, one lane can be full while the other has room, which exercises the all-or-nothing commit and the rule that a timed-out request writes no lane. An 8-bit timeout lets the bench use the all-ones value as -1, alongside short positive counts whose expiry cycle is checked exactly.

// File: rtl/cfgbuf_pkg.sv
package cfgbuf_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } wr_state_e;
endpackage

// File: rtl/cfgbuf_lane.sv
module cfgbuf_lane #(
    parameter int WIDTH = 16,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pulse,
    output logic             full,
    output logic             primed,
    output logic [WIDTH-1:0] out_word,
    output logic             strobe
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PW-1:0]    wr_ptr, rd_ptr;
    logic [CW-1:0]    count;
    logic             pass, do_push, do_pop;

    assign pass    = push && !primed;
    assign do_push = push && primed;
    assign do_pop  = pulse && primed && (count != '0);
    assign full    = (count == CW'(DEPTH));

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr   <= '0;
            rd_ptr   <= '0;
            count    <= '0;
            primed   <= 1'b0;
            out_word <= '0;
            strobe   <= 1'b0;
        end else begin
            strobe <= 1'b0;
            if (pass) begin
                out_word <= push_data;
                primed   <= 1'b1;
                strobe   <= 1'b1;
            end else if (pulse && primed) begin
                strobe <= 1'b1;
                if (do_pop) out_word <= mem[rd_ptr];
            end
            if (do_push) wr_ptr <= (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            if (do_push && !do_pop)      count <= count + 1'b1;
            else if (do_pop && !do_push) count <= count - 1'b1;
        end
    end
endmodule

// File: rtl/cfgbuf_wrctl.sv
module cfgbuf_wrctl
    import cfgbuf_pkg::*;
#(
    parameter int LANES = 2,
    parameter int WIDTH = 16,
    parameter int TOW   = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    input  logic [LANES-1:0]       in_mask,
    input  logic [LANES*WIDTH-1:0] in_data,
    input  logic [TOW-1:0]         in_timeout,
    input  logic [LANES-1:0]       lane_full,
    output logic                   in_ready,
    output logic [LANES-1:0]       push,
    output logic [LANES*WIDTH-1:0] push_data,
    output logic                   wr_done,
    output logic                   wr_timed_out
);
    wr_state_e              state, next_state;
    logic [LANES-1:0]       req_mask, cur_mask;
    logic [LANES*WIDTH-1:0] req_data;
    logic [TOW-1:0]         cnt;
    logic                   forever_q, rdy_prev;
    logic                   accept, room, commit, expire;

    assign in_ready  = (state == ST_IDLE);
    assign cur_mask  = (state == ST_WAIT) ? req_mask : in_mask;
    assign push_data = (state == ST_WAIT) ? req_data : in_data;
    assign room      = ~|(cur_mask & lane_full);
    assign push      = commit ? cur_mask : '0;

    always_comb begin
        accept     = 1'b0;
        commit     = 1'b0;
        expire     = 1'b0;
        next_state = state;
        unique case (state)
            ST_IDLE: begin
                accept = in_valid && rdy_prev;
                if (accept) begin
                    if (room)                  commit     = 1'b1;
                    else if (in_timeout == '0) expire     = 1'b1;
                    else                       next_state = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (room) begin
                    commit     = 1'b1;
                    next_state = ST_IDLE;
                end else if (!forever_q && cnt == TOW'(1)) begin
                    expire     = 1'b1;
                    next_state = ST_IDLE;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= next_state;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_done      <= 1'b0;
            wr_timed_out <= 1'b0;
            rdy_prev     <= 1'b1;
            req_mask     <= '0;
            req_data     <= '0;
            cnt          <= '0;
            forever_q    <= 1'b0;
        end else begin
            wr_done      <= commit;
            wr_timed_out <= expire;
            rdy_prev     <= in_ready;
            if (accept) begin
                req_mask  <= in_mask;
                req_data  <= in_data;
                cnt       <= in_timeout;
                forever_q <= in_timeout[TOW-1];
            end else if (state == ST_WAIT && !room && !forever_q) begin
                cnt <= cnt - 1'b1;
            end
        end
    end
endmodule

// File: rtl/cfg_pulse_buffer.sv
module cfg_pulse_buffer #(
    parameter int LANES = 2,
    parameter int WIDTH = 16,
    parameter int DEPTH = 4,
    parameter int TOW   = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    input  logic [LANES-1:0]       in_mask,
    input  logic [LANES*WIDTH-1:0] in_data,
    input  logic [TOW-1:0]         in_timeout,
    output logic                   in_ready,
    output logic                   wr_done,
    output logic                   wr_timed_out,
    input  logic                   sample_pulse,
    output logic [LANES-1:0]       lane_primed,
    output logic [LANES*WIDTH-1:0] cfg_out,
    output logic [LANES-1:0]       cfg_strobe
);
    logic [LANES-1:0]       lane_full, push;
    logic [LANES*WIDTH-1:0] push_data;

    cfgbuf_wrctl #(.LANES(LANES), .WIDTH(WIDTH), .TOW(TOW)) u_wrctl (
        .clk          (clk),
        .rst_n        (rst_n),
        .in_valid     (in_valid),
        .in_mask      (in_mask),
        .in_data      (in_data),
        .in_timeout   (in_timeout),
        .lane_full    (lane_full),
        .in_ready     (in_ready),
        .push         (push),
        .push_data    (push_data),
        .wr_done      (wr_done),
        .wr_timed_out (wr_timed_out)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        cfgbuf_lane #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_lane (
            .clk       (clk),
            .rst_n     (rst_n),
            .push      (push[g]),
            .push_data (push_data[g*WIDTH +: WIDTH]),
            .pulse     (sample_pulse),
            .full      (lane_full[g]),
            .primed    (lane_primed[g]),
            .out_word  (cfg_out[g*WIDTH +: WIDTH]),
            .strobe    (cfg_strobe[g])
        );
    end
endmodule

// File: rtl/cfgbuf_checker.sv
module cfgbuf_checker #(
    parameter int LANES = 2,
    parameter int WIDTH = 16,
    parameter int TOW   = 16
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   in_valid,
    input logic [LANES-1:0]       in_mask,
    input logic [LANES*WIDTH-1:0] in_data,
    input logic [TOW-1:0]         in_timeout,
    input logic                   in_ready,
    input logic                   wr_done,
    input logic                   wr_timed_out,
    input logic                   sample_pulse,
    input logic [LANES-1:0]       lane_primed,
    input logic [LANES*WIDTH-1:0] cfg_out,
    input logic [LANES-1:0]       cfg_strobe
);
    AST_DONE_XOR_EXPIRE: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_done && wr_timed_out)); // R6
    AST_DONE_BACK_TO_READY: assert property (@(posedge clk) disable iff (!rst_n)
        wr_done |-> in_ready); // R11
    AST_EXPIRE_BACK_TO_READY: assert property (@(posedge clk) disable iff (!rst_n)
        wr_timed_out |-> in_ready); // R7

    for (genvar g = 0; g < LANES; g++) begin : g_chk
        AST_PRIMED_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
            lane_primed[g] |=> lane_primed[g]); // R2
        AST_STROBE_NEEDS_PRIME: assert property (@(posedge clk) disable iff (!rst_n)
            cfg_strobe[g] |-> lane_primed[g]); // R3
        AST_HOLD_WITHOUT_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
            !cfg_strobe[g] |-> $stable(cfg_out[g*WIDTH +: WIDTH])); // R4
        AST_PULSE_STROBES: assert property (@(posedge clk) disable iff (!rst_n)
            (sample_pulse && lane_primed[g]) |=> cfg_strobe[g]); // R5
    end
endmodule

bind cfg_pulse_buffer cfgbuf_checker #(.LANES(LANES), .WIDTH(WIDTH), .TOW(TOW)) u_cfgbuf_chk (.*);

// File: tb/test_cfg_pulse_buffer.sv
module test_cfg_pulse_buffer;
    localparam int CLK_PERIOD = 10;
    localparam int LANES = 2;
    localparam int WIDTH = 16;
    localparam int DEPTH = 4;
    localparam int TOW   = 8;

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic                   in_valid = 1'b0;
    logic [LANES-1:0]       in_mask = '0;
    logic [LANES*WIDTH-1:0] in_data = '0;
    logic [TOW-1:0]         in_timeout = '0;
    logic                   in_ready, wr_done, wr_timed_out;
    logic                   sample_pulse = 1'b0;
    logic [LANES-1:0]       lane_primed, cfg_strobe;
    logic [LANES*WIDTH-1:0] cfg_out;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cfg_pulse_buffer #(.LANES(LANES), .WIDTH(WIDTH), .DEPTH(DEPTH), .TOW(TOW)) i_cfg_pulse_buffer (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_mask(in_mask),
        .in_data(in_data), .in_timeout(in_timeout), .in_ready(in_ready),
        .wr_done(wr_done), .wr_timed_out(wr_timed_out), .sample_pulse(sample_pulse),
        .lane_primed(lane_primed), .cfg_out(cfg_out), .cfg_strobe(cfg_strobe)
    );

    function automatic logic [WIDTH-1:0] lane_word(input int i);
        return cfg_out[i*WIDTH +: WIDTH];
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic chk_eq(input string req, input logic [63:0] act, input logic [63:0] exp);
        chk(act == exp, req, act, exp);
    endtask

    task automatic do_write(input logic [1:0] m, input logic [WIDTH-1:0] d0, input logic [WIDTH-1:0] d1,
                            input logic [TOW-1:0] t, input int lim,
                            output bit gd, output bit gt, output int k);
        @(negedge clk);
        in_valid = 1'b1; in_mask = m; in_data = {d1, d0}; in_timeout = t;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0; in_mask = '0;
        k = 0;
        while (!(wr_done || wr_timed_out) && k < lim) begin
            @(posedge clk);
            @(negedge clk);
            k++;
        end
        gd = wr_done; gt = wr_timed_out;
    endtask

    task automatic do_pulse();
        @(negedge clk);
        sample_pulse = 1'b1;
        @(posedge clk);
        @(negedge clk);
        sample_pulse = 1'b0;
    endtask

    task automatic t_reset();
        chk_eq("R1 ready", in_ready, 1);
        chk_eq("R1 primed", lane_primed, 0);
        chk_eq("R1 out", cfg_out, 0);
        chk_eq("R1 strobe", cfg_strobe, 0);
        chk_eq("R1 done/to", {wr_done, wr_timed_out}, 0);
    endtask

    task automatic t_gated();
        do_pulse();
        chk_eq("R3 no strobe unprimed", cfg_strobe, 0);
        chk_eq("R3 out unchanged", cfg_out, 0);
    endtask

    task automatic t_pass();
        bit gd, gt; int k;
        do_write(2'b01, 16'hA000, 16'h0, 8'd0, 5, gd, gt, k);
        chk_eq("R2 lane0 done", {gd, gt, k[3:0]}, {1'b1, 1'b0, 4'd0});
        chk_eq("R2 lane0 passthrough", lane_word(0), 16'hA000);
        chk_eq("R2 lane0 strobe", cfg_strobe, 2'b01);
        chk_eq("R2 primed lane0 only", lane_primed, 2'b01);
        do_write(2'b10, 16'h0, 16'hB000, 8'd0, 5, gd, gt, k);
        chk_eq("R2 lane1 passthrough", lane_word(1), 16'hB000);
        chk_eq("R2 lane0 kept", lane_word(0), 16'hA000);
        chk_eq("R2 both primed", lane_primed, 2'b11);
    endtask

    task automatic t_fifo();
        bit gd, gt; int k;
        do_write(2'b01, 16'hA001, 16'h0, 8'd0, 5, gd, gt, k);
        chk_eq("R4 queued commit", gd, 1);
        chk_eq("R4 no strobe on queue", cfg_strobe, 0);
        do_write(2'b01, 16'hA002, 16'h0, 8'd0, 5, gd, gt, k);
        chk_eq("R4 out held", lane_word(0), 16'hA000);
        do_pulse();
        chk_eq("R4 oldest first", lane_word(0), 16'hA001);
        chk_eq("R5 empty lane1 replays", {cfg_strobe, lane_word(1)}, {2'b11, 16'hB000});
        do_pulse();
        chk_eq("R4 second word", lane_word(0), 16'hA002);
        do_pulse();
        chk_eq("R5 replay lane0", {cfg_strobe, lane_word(0)}, {2'b11, 16'hA002});
    endtask

    task automatic t_multi();
        bit gd, gt; int k;
        do_write(2'b11, 16'hC001, 16'hD001, 8'd0, 5, gd, gt, k);
        chk_eq("R10 both lanes commit", gd, 1);
        do_pulse();
        chk_eq("R10 both lanes updated", cfg_out, {16'hD001, 16'hC001});
    endtask

    task automatic t_timeout();
        bit gd, gt; int k;
        for (int i = 1; i <= DEPTH; i++) begin
            do_write(2'b01, 16'hE000 + 16'(i), 16'h0, 8'd0, 5, gd, gt, k);
        end
        chk_eq("R6 fill commits", gd, 1);
        do_write(2'b01, 16'hEEEE, 16'h0, 8'd0, 5, gd, gt, k);
        chk_eq("R7 zero timeout immediate", {gd, gt, k[3:0]}, {1'b0, 1'b1, 4'd0});
        @(negedge clk);
        in_valid = 1'b1; in_mask = 2'b11; in_data = {16'hFFF1, 16'hFFF0}; in_timeout = 8'd3;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        chk_eq("R11 ready low in wait", in_ready, 0);
        k = 0;
        while (!(wr_done || wr_timed_out) && k < 10) begin
            @(posedge clk); @(negedge clk); k++;
        end
        chk_eq("R6 expires after T ticks", {wr_done, wr_timed_out, k[3:0]}, {1'b0, 1'b1, 4'd3});
        do_pulse();
        chk_eq("R9 lane0 queue intact", lane_word(0), 16'hE001);
        chk_eq("R9 lane1 not written", lane_word(1), 16'hD001);
    endtask

    task automatic t_forever();
        bit gd, gt; int k;
        do_write(2'b01, 16'hE006, 16'h0, 8'd0, 5, gd, gt, k);
        chk_eq("R6 refill commit", gd, 1);
        do_write(2'b01, 16'hE007, 16'h0, 8'hFF, 20, gd, gt, k);
        chk_eq("R8 no expiry", {gd, gt}, 2'b00);
        chk_eq("R11 ready low while waiting", in_ready, 0);
        do_pulse();
        chk_eq("R6 pop during wait", lane_word(0), 16'hE002);
        @(negedge clk);
        chk_eq("R8 commit once room", wr_done, 1);
        in_valid = 1'b1; in_mask = 2'b10; in_data = {16'hF001, 16'h0}; in_timeout = 8'd0;
        @(negedge clk);
        in_valid = 1'b0; in_mask = '0;
        chk_eq("R11 discarded request", {wr_done, wr_timed_out}, 2'b00);
        do_pulse(); chk_eq("R6 order E3", lane_word(0), 16'hE003);
        chk_eq("R11 lane1 not written", lane_word(1), 16'hD001);
        do_pulse(); chk_eq("R6 order E4", lane_word(0), 16'hE004);
        do_pulse(); chk_eq("R6 order E6", lane_word(0), 16'hE006);
        do_pulse(); chk_eq("R6 no overwrite E7", lane_word(0), 16'hE007);
        do_pulse(); chk_eq("R5 replay after drain", {cfg_strobe[0], lane_word(0)}, {1'b1, 16'hE007});
        chk_eq("R2 primed held", lane_primed, 2'b11);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_gated();
        t_pass();
        t_fifo();
        t_multi();
        t_timeout();
        t_forever();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule